// File: doc/BRIEF.md
# Programmable Trigger Match Unit

This block watches the sampled logic channels of a capture engine and, for every sample flagged valid, decides whether that sample meets one programmed condition. The outcome is a registered one-bit match flag that a downstream trigger sequencer consumes. Several units can sit in parallel on the same channel bus, each with its own configuration.

The condition is chosen by a match-kind code and shaped by static configuration words. A care mask marks which channels take part; a cleared care bit is a "don't care" (X). A level word gives the 0/1 value for ternary pattern matching. A reference word is the constant for the equality and magnitude relations. A per-channel two-bit edge field selects the edges of interest. A hold count sets how many consecutive samples the cared channels must stay unchanged for the stability test. The unit keeps the previous valid sample and a run-length counter so that edge and stability tests work across samples. Invalid samples are skipped, not counted.

The channel width is a parameter (18 by default, 36 being the other usual build), as is the width of the run-length counter.

Top module: `trig_match_unit`

## Requirements
- R1: `hit` is registered: one clock after an edge where `smp_valid` was 1 it shows the match result for the sample presented at that edge; one clock after an edge where `smp_valid` was 0 it is 0; it is 0 while reset is asserted.
- R2: Kind code 0 (pattern) matches when every channel whose `cfg_care` bit is 1 equals the matching `cfg_level` bit; channels with `cfg_care` 0 are don't care.
- R3: Kind codes 3 (equal), 4 (not equal), 5 (greater), 6 (greater or equal), 7 (less), 8 (less or equal) compare `smp_data & cfg_care` against `cfg_ref & cfg_care` as unsigned numbers.
- R4: Kind code 1 (edge) uses `cfg_edge[2i+1:2i]` for channel i (00 ignore, 01 rising, 10 falling, 11 either) and matches when at least one channel shows its selected edge between the previous valid sample and the current one.
- R5: The first valid sample after reset has no predecessor: it never gives an edge match, and its stability run length is 1.
- R6: Kind code 2 (stable) matches when the current run length is at least `cfg_hold`; the run length counts consecutive valid samples, including the current one, whose cared channels equal those of the sample before; a change resets it to 1; it saturates at its all-ones value; `cfg_hold` 0 matches every valid sample.
- R7: A sample with `smp_valid` 0 does not update the stored previous sample or the run length.
- R8: Kind codes 9 to 15 never match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Current sample is valid |
| smp_data | input | CH_W | Channel sample |
| cfg_kind | input | 4 | Match kind code |
| cfg_care | input | CH_W | 1 = channel takes part, 0 = don't care |
| cfg_level | input | CH_W | Pattern value per channel |
| cfg_edge | input | 2*CH_W | Edge select, two bits per channel |
| cfg_ref | input | CH_W | Constant for equality and magnitude kinds |
| cfg_hold | input | CNT_W | Required run length for the stable kind |
| hit | output | 1 | Registered match flag |

## Verification
The assertions take the configuration words to be steady over the sample they apply to and only sampled at the clock edge where the sample is valid, and they are disabled until the internally synchronized reset has released. The bench changes configuration only between samples, after the clock edge and well before the next one, and waits out the reset synchronizer before presenting any valid sample. A four-channel build is swept exhaustively for pattern and magnitude kinds over every data, mask and constant combination, while the edge and stable kinds run long pseudo-random streams, with invalid gaps mixed into the stable stream, against an arithmetic model in the bench.

// File: rtl/trig_match_pkg.sv
package trig_match_pkg;

  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    MK_PATTERN = 4'd0,
    MK_EDGE    = 4'd1,
    MK_STABLE  = 4'd2,
    MK_EQ      = 4'd3,
    MK_NE      = 4'd4,
    MK_GT      = 4'd5,
    MK_GE      = 4'd6,
    MK_LT      = 4'd7,
    MK_LE      = 4'd8
  } match_kind_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

endpackage

// File: rtl/tm_rst_sync.sv
module tm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_core_n = stage_q[1];

endmodule

// File: rtl/tm_history.sv
module tm_history #(
  parameter int CH_W  = 18,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [CH_W-1:0]  smp_data,
  input  logic [CH_W-1:0]  cfg_care,
  output logic [CH_W-1:0]  prev_data,
  output logic             prev_ok,
  output logic [CNT_W-1:0] run_len
);

  localparam logic [CNT_W-1:0] RUN_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

  logic [CH_W-1:0]  prev_q, prev_d;
  logic             ok_q, ok_d;
  logic [CNT_W-1:0] run_q, run_d, run_cur;
  logic             same_cared;

  // run length of the current sample, counting itself
  always_comb begin
    same_cared = ok_q && (((smp_data ^ prev_q) & cfg_care) == '0);
    if (!same_cared) begin
      run_cur = RUN_ONE;
    end else if (run_q == RUN_MAX) begin
      run_cur = RUN_MAX;
    end else begin
      run_cur = run_q + RUN_ONE;
    end
  end

  // next state, advanced only on valid samples
  always_comb begin
    prev_d = prev_q;
    ok_d   = ok_q;
    run_d  = run_q;
    if (smp_valid) begin
      prev_d = smp_data;
      ok_d   = 1'b1;
      run_d  = run_cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      ok_q   <= 1'b0;
      run_q  <= '0;
    end else begin
      prev_q <= prev_d;
      ok_q   <= ok_d;
      run_q  <= run_d;
    end
  end

  assign prev_data = prev_q;
  assign prev_ok   = ok_q;
  assign run_len   = run_cur;

endmodule

// File: rtl/tm_edge_detect.sv
module tm_edge_detect
  import trig_match_pkg::*;
#(
  parameter int CH_W = 18
) (
  input  logic [CH_W-1:0]   cur_data,
  input  logic [CH_W-1:0]   prev_data,
  input  logic              prev_ok,
  input  logic [2*CH_W-1:0] cfg_edge,
  output logic              edge_hit
);

  logic [CH_W-1:0] ch_hit;

  for (genvar i = 0; i < CH_W; i++) begin : g_ch
    edge_sel_e sel;
    logic      rose, fell, want_rise, want_fall;
    assign sel       = edge_sel_e'(cfg_edge[2*i +: 2]);
    assign rose      = ~prev_data[i] & cur_data[i];
    assign fell      = prev_data[i] & ~cur_data[i];
    assign want_rise = (sel == EDGE_RISE) || (sel == EDGE_ANY);
    assign want_fall = (sel == EDGE_FALL) || (sel == EDGE_ANY);
    assign ch_hit[i] = (want_rise & rose) | (want_fall & fell);
  end

  assign edge_hit = prev_ok & (|ch_hit);

endmodule

// File: rtl/tm_compare.sv
module tm_compare
  import trig_match_pkg::*;
#(
  parameter int CH_W = 18
) (
  input  logic [CH_W-1:0] smp_data,
  input  logic [CH_W-1:0] cfg_care,
  input  logic [CH_W-1:0] cfg_level,
  input  logic [CH_W-1:0] cfg_ref,
  input  match_kind_e     kind,
  output logic            pat_hit,
  output logic            mag_hit
);

  logic [CH_W-1:0] lhs, rhs;
  logic            is_eq, is_lt;

  assign pat_hit = (((smp_data ^ cfg_level) & cfg_care) == '0);

  assign lhs   = smp_data & cfg_care;
  assign rhs   = cfg_ref & cfg_care;
  assign is_eq = (lhs == rhs);
  assign is_lt = (lhs < rhs);

  always_comb begin
    mag_hit = 1'b0;
    case (kind)
      MK_EQ:   mag_hit = is_eq;
      MK_NE:   mag_hit = ~is_eq;
      MK_GT:   mag_hit = ~is_eq & ~is_lt;
      MK_GE:   mag_hit = ~is_lt;
      MK_LT:   mag_hit = is_lt;
      MK_LE:   mag_hit = is_lt | is_eq;
      default: mag_hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
  import trig_match_pkg::*;
#(
  parameter int CH_W  = 18,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CH_W-1:0]   smp_data,
  input  logic [KIND_W-1:0] cfg_kind,
  input  logic [CH_W-1:0]   cfg_care,
  input  logic [CH_W-1:0]   cfg_level,
  input  logic [2*CH_W-1:0] cfg_edge,
  input  logic [CH_W-1:0]   cfg_ref,
  input  logic [CNT_W-1:0]  cfg_hold,
  output logic              hit
);

  logic             rst_core_n;
  match_kind_e      kind;
  logic [CH_W-1:0]  prev_data;
  logic             prev_ok;
  logic [CNT_W-1:0] run_len;
  logic             pat_hit, mag_hit, edge_hit, stable_hit;
  logic             match_d, hit_d, hit_q;

  assign kind = match_kind_e'(cfg_kind);

  tm_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  tm_history #(.CH_W(CH_W), .CNT_W(CNT_W)) u_history (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .cfg_care  (cfg_care),
    .prev_data (prev_data),
    .prev_ok   (prev_ok),
    .run_len   (run_len)
  );

  tm_edge_detect #(.CH_W(CH_W)) u_edge (
    .cur_data  (smp_data),
    .prev_data (prev_data),
    .prev_ok   (prev_ok),
    .cfg_edge  (cfg_edge),
    .edge_hit  (edge_hit)
  );

  tm_compare #(.CH_W(CH_W)) u_cmp (
    .smp_data  (smp_data),
    .cfg_care  (cfg_care),
    .cfg_level (cfg_level),
    .cfg_ref   (cfg_ref),
    .kind      (kind),
    .pat_hit   (pat_hit),
    .mag_hit   (mag_hit)
  );

  assign stable_hit = (run_len >= cfg_hold);

  always_comb begin
    match_d = 1'b0;
    case (kind)
      MK_PATTERN: match_d = pat_hit;
      MK_EDGE:    match_d = edge_hit;
      MK_STABLE:  match_d = stable_hit;
      MK_EQ, MK_NE, MK_GT, MK_GE, MK_LT, MK_LE: match_d = mag_hit;
      default:    match_d = 1'b0;
    endcase
    hit_d = smp_valid & match_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
    end
  end

  assign hit = hit_q;

endmodule

// File: rtl/trig_match_chk.sv
module trig_match_chk #(
  parameter int CH_W  = 18,
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [CH_W-1:0]   smp_data,
  input logic [3:0]        cfg_kind,
  input logic [CH_W-1:0]   cfg_care,
  input logic [CH_W-1:0]   cfg_level,
  input logic [2*CH_W-1:0] cfg_edge,
  input logic [CH_W-1:0]   cfg_ref,
  input logic [CNT_W-1:0]  cfg_hold,
  input logic              hit
);

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !hit);

  // R1
  hit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(smp_valid));

  // R2
  pattern_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && cfg_kind == 4'd0 && ((smp_data ^ cfg_level) & cfg_care) == '0) |=> hit);

  // R3
  eq_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && cfg_kind == 4'd3 && (smp_data & cfg_care) == (cfg_ref & cfg_care)) |=> hit);

  // R3
  ne_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_kind == 4'd4 && (smp_data & cfg_care) == (cfg_ref & cfg_care)) |=> !hit);

  // R4
  edge_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_kind == 4'd1 && cfg_edge == '0) |=> !hit);

  // R6
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && cfg_kind == 4'd2 && cfg_hold == '0) |=> hit);

  // R8
  bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_kind > 4'd8) |=> !hit);

endmodule

bind trig_match_unit trig_match_chk #(.CH_W(CH_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .smp_valid (smp_valid),
  .smp_data  (smp_data),
  .cfg_kind  (cfg_kind),
  .cfg_care  (cfg_care),
  .cfg_level (cfg_level),
  .cfg_edge  (cfg_edge),
  .cfg_ref   (cfg_ref),
  .cfg_hold  (cfg_hold),
  .hit       (hit)
);

// File: tb/tb_trig_match_unit.sv
module tb_trig_match_unit;

  localparam int CLK_PERIOD = 10;
  localparam int CH_W       = 4;
  localparam int CNT_W      = 8;
  localparam int MAX_CYCLES = 200000;

  logic              clk;
  logic              rst_n;
  logic              smp_valid;
  logic [CH_W-1:0]   smp_data;
  logic [3:0]        cfg_kind;
  logic [CH_W-1:0]   cfg_care;
  logic [CH_W-1:0]   cfg_level;
  logic [2*CH_W-1:0] cfg_edge;
  logic [CH_W-1:0]   cfg_ref;
  logic [CNT_W-1:0]  cfg_hold;
  logic              hit;

  int checks;
  int errors;
  int cycles;
  logic done;

  // bench model state
  logic [CH_W-1:0] m_prev;
  logic            m_have;
  int              m_run;
  logic [15:0]     lfsr;

  trig_match_unit #(.CH_W(CH_W), .CNT_W(CNT_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .cfg_kind  (cfg_kind),
    .cfg_care  (cfg_care),
    .cfg_level (cfg_level),
    .cfg_edge  (cfg_edge),
    .cfg_ref   (cfg_ref),
    .cfg_hold  (cfg_hold),
    .hit       (hit)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: hit=%0b expected=%0b (kind=%0d data=%h care=%h)",
               req, act, exp, cfg_kind, smp_data, cfg_care);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // present one sample, compute the expected flag, check one clock later
  task automatic sample(input logic v, input logic [CH_W-1:0] d, input string req);
    logic exp;
    int   run_new;
    logic same;
    logic [CH_W-1:0] a, b;
    exp = 1'b0;
    run_new = m_run;
    if (v) begin
      same = m_have && (((d ^ m_prev) & cfg_care) == '0);
      run_new = same ? ((m_run == 255) ? 255 : m_run + 1) : 1;
      a = d & cfg_care;
      b = cfg_ref & cfg_care;
      case (cfg_kind)
        4'd0: exp = (((d ^ cfg_level) & cfg_care) == '0);
        4'd1: begin
          if (m_have) begin
            for (int i = 0; i < CH_W; i++) begin
              if (cfg_edge[2*i]   && !m_prev[i] &&  d[i]) exp = 1'b1;
              if (cfg_edge[2*i+1] &&  m_prev[i] && !d[i]) exp = 1'b1;
            end
          end
        end
        4'd2: exp = (run_new >= int'(cfg_hold));
        4'd3: exp = (a == b);
        4'd4: exp = (a != b);
        4'd5: exp = (a > b);
        4'd6: exp = (a >= b);
        4'd7: exp = (a < b);
        4'd8: exp = (a <= b);
        default: exp = 1'b0;
      endcase
    end
    @(negedge clk);
    smp_valid = v;
    smp_data  = d;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(hit === exp, req, hit, exp);
    if (v) begin
      m_prev = d;
      m_have = 1'b1;
      m_run  = run_new;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    smp_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: flag low in reset
    check(hit === 1'b0, "R1 reset", hit, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(hit === 1'b0, "R1 after reset", hit, 1'b0);
    m_prev = '0;
    m_have = 1'b0;
    m_run  = 0;
  endtask

  initial begin
    cycles = 0;
    wait (done === 1'b0);
    while (!done && cycles < MAX_CYCLES) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected<%0d", cycles, MAX_CYCLES);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    done = 1'b0;
    checks = 0;
    errors = 0;
    lfsr = 16'hACE1;
    rst_n = 1'b0;
    smp_valid = 1'b0;
    smp_data = '0;
    cfg_kind = 4'd0;
    cfg_care = '0;
    cfg_level = '0;
    cfg_edge = '0;
    cfg_ref = '0;
    cfg_hold = '0;
    m_prev = '0;
    m_have = 1'b0;
    m_run = 0;

    do_reset();

    // R5: first valid sample after reset gives no edge
    cfg_kind = 4'd1;
    cfg_edge = '1;
    sample(1'b1, 4'hF, "R5 first edge");
    sample(1'b1, 4'h0, "R4 fall after first");

    // R5: first stable run is 1
    do_reset();
    cfg_kind = 4'd2;
    cfg_care = '1;
    cfg_hold = 8'd2;
    sample(1'b1, 4'h3, "R5 first run below hold");
    sample(1'b1, 4'h3, "R6 run reaches hold");
    do_reset();
    cfg_hold = 8'd1;
    sample(1'b1, 4'h9, "R5 first run meets hold 1");

    // R2: exhaustive ternary pattern
    cfg_kind = 4'd0;
    for (int c = 0; c < 16; c++) begin
      for (int l = 0; l < 16; l++) begin
        cfg_care  = 4'(c);
        cfg_level = 4'(l);
        for (int d = 0; d < 16; d++) sample(1'b1, 4'(d), "R2 pattern");
      end
    end

    // R3: exhaustive magnitude kinds
    for (int k = 3; k <= 8; k++) begin
      cfg_kind = 4'(k);
      for (int c = 0; c < 16; c++) begin
        for (int r = 0; r < 16; r++) begin
          cfg_care = 4'(c);
          cfg_ref  = 4'(r);
          for (int d = 0; d < 16; d++) sample(1'b1, 4'(d), "R3 magnitude");
        end
      end
    end

    // R8: unused kind codes
    for (int k = 9; k < 16; k++) begin
      cfg_kind = 4'(k);
      cfg_care = '0;
      for (int d = 0; d < 16; d++) sample(1'b1, 4'(d), "R8 unused kind");
    end

    // R4: every edge select against a pseudo-random stream
    cfg_kind = 4'd1;
    for (int s = 0; s < 256; s++) begin
      cfg_edge = 8'(s);
      for (int n = 0; n < 48; n++) begin
        step_lfsr();
        sample(1'b1, lfsr[3:0], "R4 edge");
      end
    end

    // R6/R7: stable with holds, runs and invalid gaps
    cfg_kind = 4'd2;
    for (int c = 0; c < 16; c++) begin
      for (int h = 0; h < 6; h++) begin
        logic [CH_W-1:0] held;
        cfg_care = 4'(c);
        cfg_hold = 8'(h);
        held = lfsr[3:0];
        for (int n = 0; n < 48; n++) begin
          step_lfsr();
          if (lfsr[5:4] == 2'b00) held = lfsr[3:0];
          if (lfsr[9:7] == 3'b000) sample(1'b0, lfsr[15:12], "R7 invalid gap");
          else sample(1'b1, held, "R6 stable");
        end
      end
    end

    // R6: saturation of the run length at all-ones
    cfg_care = '1;
    cfg_hold = 8'd255;
    sample(1'b1, 4'h6, "R6 start run");
    for (int n = 0; n < 260; n++) sample(1'b1, 4'h5, "R6 saturation");

    // R7: gap does not disturb the edge reference
    cfg_kind = 4'd1;
    cfg_edge = 8'h55;
    sample(1'b1, 4'h0, "R4 base");
    sample(1'b0, 4'hF, "R7 gap ignored");
    sample(1'b1, 4'h0, "R7 no edge across gap");
    sample(1'b1, 4'h1, "R4 rise");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule